// File: doc/BRIEF.md
# Calendar Field BCD/Binary Codec

This block sits between a clock-calendar counter, which keeps its seconds, minutes, hours, weekday, day of month, month and year as plain binary numbers, and the byte-wide register view seen by software. In the forward direction it turns the seven binary fields into seven register bytes. Two control bits choose the byte format. `bin_mode` picks packed decimal digits or straight binary. `hour24` picks a 24-hour clock, or a 12-hour clock with an afternoon flag in bit 7. The month index is zero-based on the input and one-based in the byte. The year is a full year on the input and its last two digits in the byte.

In the reverse direction, seven bytes written by software are turned back into binary fields using the same two control bits. The month offset and the century base are undone, so a value written by software can be loaded straight into the counter. Both directions are pure logic. When the `REG_OUT` parameter is set, a single output register stage is added to every output. The block does no calendar counting.

Top module: `tfield_codec`

## Requirements
- R1: With `REG_OUT`=1 (default), every output takes the value computed from the inputs present at the previous rising clock edge. While `rst_n` is low, every output is zero.
- R2: With `bin_mode`=0, each encoded field places its tens digit in bits 7:4 and its units digit in bits 3:0 (for example 47 encodes as 0x47).
- R3: With `hour24`=1, the hour is encoded like any other field, and bit 7 is never added for hours 0 to 23.
- R4: With `hour24`=0, the hour code holds hour mod 12 in its low seven bits, and bit 7 is set when the hour is 12 or more. In packed-decimal mode, hour 0 gives 0x00, hour 12 gives 0x80 and hour 23 gives 0x91.
- R5: The month byte encodes month index + 1 (index 0 gives 0x01 and index 11 gives 0x12 in packed-decimal mode). The year byte encodes the full year mod 100.
- R6: Decode turns a packed-decimal byte into high nibble × 10 + low nibble, and passes a byte through unchanged in binary mode. The decoded month is the value minus 1. The decoded year is `YEAR_BASE` (2000) plus the value. With `hour24`=0, bit 7 of the hour byte adds 12 to the value of its low seven bits.
- R7: With `bin_mode`=0, a seconds, minutes, weekday, day-of-month or 24-hour hour input above 99 encodes as 0x99 and raises `range_err`. With `bin_mode`=1, `range_err` stays 0 and the byte is the low 8 bits of the input.
- R8: With `bin_mode`=1, every field is encoded as its binary value (for example seconds 59 give 0x3B).
- R9: For in-range inputs (year 2000 to 2099), decoding the bytes produced by the encoder returns the original fields in all four combinations of `bin_mode` and `hour24`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| bin_mode | input | 1 | 1 selects binary bytes, 0 selects packed decimal digits |
| hour24 | input | 1 | 1 selects the 24-hour clock, 0 the 12-hour clock with an afternoon flag |
| t_sec | input | FIELD_W | Binary seconds |
| t_min | input | FIELD_W | Binary minutes |
| t_hour | input | FIELD_W | Binary hour, 0 to 23 |
| t_wday | input | FIELD_W | Binary day of week |
| t_mday | input | FIELD_W | Binary day of month |
| t_mon | input | MON_W | Zero-based month index |
| t_year | input | YEAR_W | Full binary year |
| e_sec | output | 8 | Encoded seconds byte |
| e_min | output | 8 | Encoded minutes byte |
| e_hour | output | 8 | Encoded hour byte |
| e_wday | output | 8 | Encoded weekday byte |
| e_mday | output | 8 | Encoded day-of-month byte |
| e_mon | output | 8 | Encoded month byte |
| e_year | output | 8 | Encoded two-digit year byte |
| range_err | output | 1 | A field exceeded 99 in packed-decimal mode |
| r_sec | input | 8 | Software-written seconds byte |
| r_min | input | 8 | Software-written minutes byte |
| r_hour | input | 8 | Software-written hour byte |
| r_wday | input | 8 | Software-written weekday byte |
| r_mday | input | 8 | Software-written day-of-month byte |
| r_mon | input | 8 | Software-written month byte |
| r_year | input | 8 | Software-written year byte |
| d_sec | output | 8 | Decoded seconds |
| d_min | output | 8 | Decoded minutes |
| d_hour | output | 8 | Decoded hour, 0 to 23 |
| d_wday | output | 8 | Decoded weekday |
| d_mday | output | 8 | Decoded day of month |
| d_mon | output | 8 | Decoded zero-based month index |
| d_year | output | YEAR_W | Decoded full year |

## Verification
A directed sweep runs every hour from 0 to 23 through all four mode pairs. This separates the midnight and noon codes, the afternoon flag and the mod-12 fold, and it catches a decoder that adds 12 at the wrong point. Random calendar values in random modes then compare every encoded byte against bench functions and loop the codes back through the decoder. This catches digit-split, month-offset and year-base errors that a single fixed pattern could mask. Directed cases push seconds and hours past 99, and the year past its century, to separate clamping and error flagging from plain binary pass-through. A one-cycle probe after an input change confirms the register stage.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

   typedef logic [7:0] code_t;

   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_WDAY = 3'd3,
      FLD_MDAY = 3'd4,
      FLD_MON  = 3'd5,
      FLD_YEAR = 3'd6
   } field_e;

   localparam int unsigned NUM_FIELDS = 7;
   localparam int unsigned MAX_DEC    = 99;

   // value must already be limited to 0..99
   function automatic code_t pack_digits(input logic [6:0] v);
      logic [3:0] tens;
      logic [3:0] ones;
      tens = 4'(v / 7'd10);
      ones = 4'(v % 7'd10);
      return {tens, ones};
   endfunction

   function automatic logic [7:0] unpack_digits(input code_t c);
      return ({4'd0, c[7:4]} * 8'd10) + {4'd0, c[3:0]};
   endfunction

endpackage

// File: rtl/tfc_byte_enc.sv
module tfc_byte_enc #(
   parameter int unsigned IN_W = 7
) (
   input  logic [IN_W-1:0] val,
   input  logic            bin_mode,
   output tfc_pkg::code_t  code,
   output logic            over
);
   import tfc_pkg::*;

   localparam logic [IN_W-1:0] CAP = IN_W'(MAX_DEC);

   if (IN_W < 7 || IN_W > 8) begin : g_bad_width
      $error("tfc_byte_enc: IN_W must be 7 or 8");
   end

   logic       big;
   logic [6:0] limited;

   assign big     = val > CAP;
   assign limited = big ? 7'(MAX_DEC) : val[6:0];

   always_comb begin
      if (bin_mode) begin
         code = 8'(val);
         over = 1'b0;
      end else begin
         code = pack_digits(limited);
         over = big;
      end
   end

endmodule

// File: rtl/tfc_hour_enc.sv
module tfc_hour_enc #(
   parameter int unsigned IN_W = 7
) (
   input  logic [IN_W-1:0] hour,
   input  logic            bin_mode,
   input  logic            hour24,
   output tfc_pkg::code_t  code,
   output logic            over
);
   import tfc_pkg::*;

   localparam logic [IN_W-1:0] HALF_DAY = IN_W'(12);

   logic [IN_W-1:0] folded;
   logic [IN_W-1:0] sel;
   logic            afternoon;
   code_t           raw;

   assign folded    = hour % HALF_DAY;
   assign afternoon = hour >= HALF_DAY;
   assign sel       = hour24 ? hour : folded;

   tfc_byte_enc #(.IN_W(IN_W)) u_digits (
      .val      (sel),
      .bin_mode (bin_mode),
      .code     (raw),
      .over     (over)
   );

   assign code = {raw[7] | (afternoon & ~hour24), raw[6:0]};

   always_comb begin
      if (!hour24) begin
         assert (code[6:0] <= 7'h11 || bin_mode)  // R4
            else $error("AST_HALF_DAY_RANGE: 12-hour code beyond 11");
      end
   end

endmodule

// File: rtl/tfc_byte_dec.sv
module tfc_byte_dec (
   input  tfc_pkg::code_t code,
   input  logic           bin_mode,
   output logic [7:0]     val
);
   import tfc_pkg::*;

   assign val = bin_mode ? code : unpack_digits(code);

endmodule

// File: rtl/tfield_codec.sv
module tfield_codec #(
   parameter int unsigned FIELD_W   = 7,
   parameter int unsigned MON_W     = 4,
   parameter int unsigned YEAR_W    = 12,
   parameter int unsigned YEAR_BASE = 2000,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bin_mode,
   input  logic              hour24,
   input  logic [FIELD_W-1:0] t_sec,
   input  logic [FIELD_W-1:0] t_min,
   input  logic [FIELD_W-1:0] t_hour,
   input  logic [FIELD_W-1:0] t_wday,
   input  logic [FIELD_W-1:0] t_mday,
   input  logic [MON_W-1:0]  t_mon,
   input  logic [YEAR_W-1:0] t_year,
   output logic [7:0]        e_sec,
   output logic [7:0]        e_min,
   output logic [7:0]        e_hour,
   output logic [7:0]        e_wday,
   output logic [7:0]        e_mday,
   output logic [7:0]        e_mon,
   output logic [7:0]        e_year,
   output logic              range_err,
   input  logic [7:0]        r_sec,
   input  logic [7:0]        r_min,
   input  logic [7:0]        r_hour,
   input  logic [7:0]        r_wday,
   input  logic [7:0]        r_mday,
   input  logic [7:0]        r_mon,
   input  logic [7:0]        r_year,
   output logic [7:0]        d_sec,
   output logic [7:0]        d_min,
   output logic [7:0]        d_hour,
   output logic [7:0]        d_wday,
   output logic [7:0]        d_mday,
   output logic [7:0]        d_mon,
   output logic [YEAR_W-1:0] d_year
);
   import tfc_pkg::*;

   localparam int unsigned NPLAIN   = 5;
   localparam int unsigned NDEC     = 6;
   localparam int unsigned YEAR_MAX = (1 << YEAR_W) - 1;

   if (FIELD_W < 7 || FIELD_W > 8) begin : g_bad_field
      $error("tfield_codec: FIELD_W must be 7 or 8");
   end
   if (MON_W < 4 || MON_W > 6) begin : g_bad_mon
      $error("tfield_codec: MON_W must be 4 to 6");
   end
   if (YEAR_W < 8 || YEAR_W > 16) begin : g_bad_year
      $error("tfield_codec: YEAR_W must be 8 to 16");
   end
   if (YEAR_BASE + 165 > YEAR_MAX) begin : g_bad_base
      $error("tfield_codec: YEAR_BASE does not fit YEAR_W");
   end

   // ---------------- encode ----------------
   logic [FIELD_W-1:0] plain_in [NPLAIN];
   code_t              enc_c    [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] over_c;
   logic               err_c;
   logic [6:0]         mon_p1;
   logic [6:0]         yr_lo;

   assign plain_in[FLD_SEC]  = t_sec;
   assign plain_in[FLD_MIN]  = t_min;
   assign plain_in[FLD_HOUR] = t_hour;
   assign plain_in[FLD_WDAY] = t_wday;
   assign plain_in[FLD_MDAY] = t_mday;

   for (genvar gi = 0; gi < NPLAIN; gi++) begin : g_enc
      if (gi == FLD_HOUR) begin : g_hour
         tfc_hour_enc #(.IN_W(FIELD_W)) u_hour (
            .hour     (plain_in[gi]),
            .bin_mode (bin_mode),
            .hour24   (hour24),
            .code     (enc_c[gi]),
            .over     (over_c[gi])
         );
      end else begin : g_plain
         tfc_byte_enc #(.IN_W(FIELD_W)) u_field (
            .val      (plain_in[gi]),
            .bin_mode (bin_mode),
            .code     (enc_c[gi]),
            .over     (over_c[gi])
         );
      end
   end

   assign mon_p1 = 7'(t_mon) + 7'd1;
   assign yr_lo  = 7'(t_year % YEAR_W'(100));

   tfc_byte_enc #(.IN_W(7)) u_mon_enc (
      .val      (mon_p1),
      .bin_mode (bin_mode),
      .code     (enc_c[FLD_MON]),
      .over     (over_c[FLD_MON])
   );

   tfc_byte_enc #(.IN_W(7)) u_year_enc (
      .val      (yr_lo),
      .bin_mode (bin_mode),
      .code     (enc_c[FLD_YEAR]),
      .over     (over_c[FLD_YEAR])
   );

   assign err_c = |over_c;

   // ---------------- decode ----------------
   code_t            r_in    [NUM_FIELDS];
   logic [7:0]       dec_raw [NUM_FIELDS];
   logic [7:0]       dec_c   [NDEC];
   logic [YEAR_W-1:0] dyear_c;
   code_t            hour_body;

   assign r_in[FLD_SEC]  = r_sec;
   assign r_in[FLD_MIN]  = r_min;
   assign r_in[FLD_HOUR] = r_hour;
   assign r_in[FLD_WDAY] = r_wday;
   assign r_in[FLD_MDAY] = r_mday;
   assign r_in[FLD_MON]  = r_mon;
   assign r_in[FLD_YEAR] = r_year;

   assign hour_body = hour24 ? r_hour : {1'b0, r_hour[6:0]};

   for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_dec
      if (gi == FLD_HOUR) begin : g_hour
         tfc_byte_dec u_hour_dec (
            .code     (hour_body),
            .bin_mode (bin_mode),
            .val      (dec_raw[gi])
         );
      end else begin : g_plain
         tfc_byte_dec u_field_dec (
            .code     (r_in[gi]),
            .bin_mode (bin_mode),
            .val      (dec_raw[gi])
         );
      end
   end

   assign dec_c[FLD_SEC]  = dec_raw[FLD_SEC];
   assign dec_c[FLD_MIN]  = dec_raw[FLD_MIN];
   assign dec_c[FLD_HOUR] = dec_raw[FLD_HOUR] + ((!hour24 && r_hour[7]) ? 8'd12 : 8'd0);
   assign dec_c[FLD_WDAY] = dec_raw[FLD_WDAY];
   assign dec_c[FLD_MDAY] = dec_raw[FLD_MDAY];
   assign dec_c[FLD_MON]  = dec_raw[FLD_MON] - 8'd1;
   assign dyear_c         = YEAR_W'(YEAR_BASE) + YEAR_W'(dec_raw[FLD_YEAR]);

   // ---------------- output stage ----------------
   code_t             enc_o [NUM_FIELDS];
   logic [7:0]        dec_o [NDEC];
   logic              err_o;
   logic [YEAR_W-1:0] dyear_o;

   if (REG_OUT) begin : g_reg
      code_t             enc_q [NUM_FIELDS];
      logic [7:0]        dec_q [NDEC];
      logic              err_q;
      logic [YEAR_W-1:0] dyear_q;
      logic              primed;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_FIELDS; i++) enc_q[i] <= '0;
            for (int i = 0; i < NDEC; i++)       dec_q[i] <= '0;
            err_q   <= 1'b0;
            dyear_q <= '0;
            primed  <= 1'b0;
         end else begin
            for (int i = 0; i < NUM_FIELDS; i++) enc_q[i] <= enc_c[i];
            for (int i = 0; i < NDEC; i++)       dec_q[i] <= dec_c[i];
            err_q   <= err_c;
            dyear_q <= dyear_c;
            primed  <= 1'b1;
         end
      end

      assign enc_o   = enc_q;
      assign dec_o   = dec_q;
      assign err_o   = err_q;
      assign dyear_o = dyear_q;

      AST_DIGIT_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
         primed && !$past(bin_mode) |-> (e_sec[3:0] <= 4'd9 && e_sec[7:4] <= 4'd9 &&
                                         e_year[3:0] <= 4'd9 && e_year[7:4] <= 4'd9))
         else $error("AST_DIGIT_NIBBLES");  // R2
      AST_PM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(!hour24 && t_hour >= FIELD_W'(12)) |-> e_hour[7])
         else $error("AST_PM_FLAG");  // R4
      AST_H24_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(hour24 && t_hour < FIELD_W'(24)) |-> !e_hour[7])
         else $error("AST_H24_NO_FLAG");  // R3
      AST_CLAMP_SEC: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(!bin_mode && t_sec > FIELD_W'(99)) |-> (e_sec == 8'h99 && range_err))
         else $error("AST_CLAMP_SEC");  // R7
      AST_BIN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(bin_mode) |-> !range_err)
         else $error("AST_BIN_NO_ERR");  // R7
      AST_MONTH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(!bin_mode && r_mon == 8'h01) |-> d_mon == 8'd0)
         else $error("AST_MONTH_FIRST");  // R6
   end else begin : g_comb
      assign enc_o   = enc_c;
      assign dec_o   = dec_c;
      assign err_o   = err_c;
      assign dyear_o = dyear_c;
   end

   assign e_sec     = enc_o[FLD_SEC];
   assign e_min     = enc_o[FLD_MIN];
   assign e_hour    = enc_o[FLD_HOUR];
   assign e_wday    = enc_o[FLD_WDAY];
   assign e_mday    = enc_o[FLD_MDAY];
   assign e_mon     = enc_o[FLD_MON];
   assign e_year    = enc_o[FLD_YEAR];
   assign range_err = err_o;
   assign d_sec     = dec_o[FLD_SEC];
   assign d_min     = dec_o[FLD_MIN];
   assign d_hour    = dec_o[FLD_HOUR];
   assign d_wday    = dec_o[FLD_WDAY];
   assign d_mday    = dec_o[FLD_MDAY];
   assign d_mon     = dec_o[FLD_MON];
   assign d_year    = dyear_o;

endmodule

// File: tb/tfield_codec_test.sv
`timescale 1ns/1ps
module tfield_codec_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bin_mode = 1'b0;
   logic        hour24 = 1'b1;
   logic [6:0]  t_sec = '0, t_min = '0, t_hour = '0, t_wday = '0, t_mday = '0;
   logic [3:0]  t_mon = '0;
   logic [11:0] t_year = '0;
   logic [7:0]  e_sec, e_min, e_hour, e_wday, e_mday, e_mon, e_year;
   logic        range_err;
   logic [7:0]  r_sec = '0, r_min = '0, r_hour = '0, r_wday = '0, r_mday = '0, r_mon = '0, r_year = '0;
   logic [7:0]  d_sec, d_min, d_hour, d_wday, d_mday, d_mon;
   logic [11:0] d_year;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tfield_codec uut (
      .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode), .hour24(hour24),
      .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday),
      .t_mday(t_mday), .t_mon(t_mon), .t_year(t_year),
      .e_sec(e_sec), .e_min(e_min), .e_hour(e_hour), .e_wday(e_wday),
      .e_mday(e_mday), .e_mon(e_mon), .e_year(e_year), .range_err(range_err),
      .r_sec(r_sec), .r_min(r_min), .r_hour(r_hour), .r_wday(r_wday),
      .r_mday(r_mday), .r_mon(r_mon), .r_year(r_year),
      .d_sec(d_sec), .d_min(d_min), .d_hour(d_hour), .d_wday(d_wday),
      .d_mday(d_mday), .d_mon(d_mon), .d_year(d_year)
   );

   function automatic logic [7:0] ref_enc(input int v, input bit bm);
      int lim;
      if (bm) return 8'(v);
      lim = (v > 99) ? 99 : v;
      return 8'(((lim / 10) << 4) | (lim % 10));
   endfunction

   function automatic logic [7:0] ref_hour(input int h, input bit bm, input bit h24);
      if (h24) return ref_enc(h, bm);
      return ref_enc(h % 12, bm) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(input int s, input int mi, input int h, input int wd, input int md,
                          input int mo, input int yr, input bit bm, input bit h24, input bit rt);
      logic [7:0] x_sec, x_min, x_hour, x_wday, x_mday, x_mon, x_year;
      bit x_err;
      string rq;
      @(negedge clk);
      bin_mode = bm; hour24 = h24;
      t_sec = 7'(s); t_min = 7'(mi); t_hour = 7'(h); t_wday = 7'(wd); t_mday = 7'(md);
      t_mon = 4'(mo); t_year = 12'(yr);
      x_sec = ref_enc(s, bm); x_min = ref_enc(mi, bm); x_hour = ref_hour(h, bm, h24);
      x_wday = ref_enc(wd, bm); x_mday = ref_enc(md, bm);
      x_mon = ref_enc(mo + 1, bm); x_year = ref_enc(yr % 100, bm);
      x_err = !bm && (s > 99 || mi > 99 || wd > 99 || md > 99 || (h24 && h > 99));
      r_sec = x_sec; r_min = x_min; r_hour = x_hour; r_wday = x_wday;
      r_mday = x_mday; r_mon = x_mon; r_year = x_year;
      @(negedge clk);
      rq = bm ? "R8" : "R2";
      chk(e_sec == x_sec, rq, e_sec, x_sec);
      chk(e_min == x_min, rq, e_min, x_min);
      chk(e_wday == x_wday, rq, e_wday, x_wday);
      chk(e_mday == x_mday, rq, e_mday, x_mday);
      chk(e_hour == x_hour, h24 ? "R3" : "R4", e_hour, x_hour);
      chk(e_mon == x_mon, "R5 month", e_mon, x_mon);
      chk(e_year == x_year, "R5 year", e_year, x_year);
      chk(range_err == x_err, "R7 range_err", range_err, x_err);
      if (rt) begin
         chk(d_sec == 8'(s), "R9 sec", d_sec, s);
         chk(d_min == 8'(mi), "R9 min", d_min, mi);
         chk(d_hour == 8'(h), "R9 hour", d_hour, h);
         chk(d_wday == 8'(wd), "R9 wday", d_wday, wd);
         chk(d_mday == 8'(md), "R9 mday", d_mday, md);
         chk(d_mon == 8'(mo), "R9 mon", d_mon, mo);
         chk(d_year == 12'(yr), "R9 year", d_year, yr);
      end
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd7321);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(e_sec == 8'h00 && e_hour == 8'h00 && e_mon == 8'h00 && !range_err, "R1 reset enc", e_mon, 0);
      chk(d_year == 12'd0 && d_mon == 8'd0, "R1 reset dec", d_year, 0);
      rst_n = 1'b1;

      // hour sweep in all four mode pairs
      for (int m = 0; m < 4; m++) begin
         for (int h = 0; h < 24; h++) begin
            run_vec(h * 2, 59 - h, h, h % 7, h + 1, h % 12, 2000 + h * 4, m[0], m[1], 1'b1);
         end
      end

      // directed corner cases
      run_vec(0, 0, 0, 0, 1, 0, 2000, 1'b0, 1'b0, 1'b1);    // midnight 0x00 (R4)
      chk(e_hour == 8'h00, "R4 midnight", e_hour, 8'h00);
      run_vec(0, 0, 12, 0, 1, 0, 2000, 1'b0, 1'b0, 1'b1);   // noon 0x80 (R4)
      chk(e_hour == 8'h80, "R4 noon", e_hour, 8'h80);
      run_vec(0, 0, 23, 0, 1, 11, 2099, 1'b0, 1'b0, 1'b1);  // 0x91, month 0x12, year 0x99
      chk(e_hour == 8'h91 && e_mon == 8'h12 && e_year == 8'h99, "R5 corners", e_mon, 8'h12);
      run_vec(100, 0, 0, 0, 1, 0, 2000, 1'b0, 1'b1, 1'b0);  // clamp (R7)
      run_vec(127, 120, 110, 0, 1, 0, 2000, 1'b0, 1'b1, 1'b0);
      run_vec(100, 127, 0, 0, 1, 0, 2000, 1'b1, 1'b1, 1'b0); // binary, no error
      run_vec(59, 59, 23, 6, 31, 11, 2099, 1'b1, 1'b1, 1'b1);
      chk(e_sec == 8'h3B, "R8 binary 59", e_sec, 8'h3B);
      run_vec(0, 0, 0, 0, 1, 0, 2100, 1'b0, 1'b1, 1'b0);    // year wraps to 0x00
      chk(e_year == 8'h00, "R5 year mod", e_year, 8'h00);

      // R6: directed decode
      @(negedge clk);
      bin_mode = 1'b0; hour24 = 1'b0;
      r_sec = 8'h45; r_mon = 8'h01; r_year = 8'h07; r_hour = 8'h91;
      @(negedge clk);
      chk(d_sec == 8'd45, "R6 bcd sec", d_sec, 45);
      chk(d_mon == 8'd0, "R6 month", d_mon, 0);
      chk(d_year == 12'd2007, "R6 year", d_year, 2007);
      chk(d_hour == 8'd23, "R6 pm hour", d_hour, 23);
      bin_mode = 1'b1; hour24 = 1'b1; r_sec = 8'h45;
      @(negedge clk);
      chk(d_sec == 8'h45, "R6 binary pass", d_sec, 8'h45);

      // R1: one-cycle latency
      t_sec = 7'd10;
      @(negedge clk);
      t_sec = 7'd20;
      #1;
      chk(e_sec == 8'd10, "R1 holds before edge", e_sec, 10);
      @(negedge clk);
      chk(e_sec == 8'd20, "R1 after edge", e_sec, 20);

      // random
      for (int i = 0; i < 400; i++) begin
         run_vec($urandom_range(59, 0), $urandom_range(59, 0), $urandom_range(23, 0),
                 $urandom_range(6, 0), $urandom_range(31, 1), $urandom_range(11, 0),
                 $urandom_range(2099, 2000), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'b1);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule